// File: doc/BRIEF.md
# Timer Mode Control Register with Write Guard

This block is the slice of a timer peripheral's register file that holds the timer's mode bits. It sits on a simple single-cycle register bus with address, write strobe, write data, read strobe and read data. Two locations are decoded. The mode word holds five fields: a capture-test switch, a trigger-routing select, the guard-open flag, an output-initialise strobe bit and an extended-feature switch. A separate guard word holds the lock bit.

Two of the mode fields are guarded: the capture-test switch and the extended-feature switch. While the lock bit is set, writes to either field are dropped without notice. Software opens the guard with a two-step sequence. First it reads the guard word and sees the lock bit at 1. Then its next bus write goes to the mode word with the guard-open bit set. Writing 1 to the lock bit closes the guard again.

The guard-open flag is always the inverse of the lock bit. Writing 1 to the initialise bit makes the block emit a one-clock pulse. The channel output stage uses this pulse to load its outputs from their preset values.

Top module: `tmr_mode_reg`

## Requirements
- R1: After reset the lock bit is 1, the guard-open flag is 0, capture-test, trigger-select and extended-feature are 0, the initialise pulse is low and read data is 0.
- R2: The mode word is at offset 0, with capture-test at bit 0, trigger-select at bit 1, guard-open at bit 2, initialise at bit 3 and extended-feature at bit 4. The guard word is at offset 1, with the lock bit at bit 0. Read data is valid in the cycle after the read strobe. It is 0 for an unmapped offset and when no read is made.
- R3: A write to the mode word while the lock bit is 1 leaves capture-test and extended-feature unchanged. The lock state before the write decides this, so the write that opens the guard cannot also set these two fields.
- R4: Trigger-select takes the written value on every mode-word write, whatever the lock state.
- R5: The guard-open flag, both on its output and in bit 2 of the mode word, always equals the inverse of the lock bit.
- R6: Writing 1 to the lock bit sets it, and the guard closes. Writing 0 to the lock bit leaves it unchanged.
- R7: A read of the guard word that returns the lock bit as 1 arms the guard. If the next bus write goes to the mode word with bit 2 at 1, the lock bit clears.
- R8: Writing guard-open as 1 leaves the lock bit at 1 in two cases: when no arming read came first, and when another write came between the arming read and this write.
- R9: Writing 0 to the guard-open bit has no effect on the lock state.
- R10: Writing 1 to the initialise bit makes the initialise pulse high for exactly the one cycle after the write, whatever the lock state. Writing 0 to the initialise bit produces no pulse.
- R11: The initialise bit always reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Word offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Read data, valid one cycle after the read strobe |
| cap_test_o | output | 1 | Capture-test switch |
| sync_sel_o | output | 1 | Trigger-routing select |
| feat_en_o | output | 1 | Extended-feature switch |
| lock_o | output | 1 | Lock bit |
| guard_open_o | output | 1 | Guard-open flag (inverse of lock) |
| init_pulse_o | output | 1 | One-cycle output-initialise strobe |

## Verification
Every field output, the lock bit and the guard-open flag change at the first clock edge that samples a write, so they are due one cycle after the write. Read data is due one cycle after the read strobe. The initialise pulse is high only during the cycle after the write and is low again one cycle later. The bench drives each access at a falling edge and removes it at the next falling edge. It samples at that second falling edge, which lies after exactly one rising edge. For the pulse it samples once more a cycle later to confirm the pulse has fallen.

// File: rtl/tmr_mode_pkg.sv
package tmr_mode_pkg;
    // Bit positions inside the mode word
    localparam int unsigned CAPT_BIT = 0;
    localparam int unsigned SYNC_BIT = 1;
    localparam int unsigned UNLK_BIT = 2;
    localparam int unsigned INIT_BIT = 3;
    localparam int unsigned FEAT_BIT = 4;
    // Bit position inside the guard word
    localparam int unsigned LOCK_BIT = 0;

    typedef struct packed {
        logic wr_mode;
        logic wr_prot;
        logic wr_any;
        logic rd_mode;
        logic rd_prot;
    } decode_t;

    typedef struct packed {
        logic lock;
        logic armed;
    } guard_t;

    typedef struct packed {
        logic cap_test;
        logic sync_sel;
        logic feat_en;
        logic init_pls;
    } fields_t;
endpackage

// File: rtl/tmr_mode_decode.sv
module tmr_mode_decode
    import tmr_mode_pkg::*;
#(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned MODE_OFS = 0,
    parameter int unsigned PROT_OFS = 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output decode_t           dec
);
    localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(MODE_OFS);
    localparam logic [ADDR_W-1:0] PROT_A = ADDR_W'(PROT_OFS);

    always_comb begin
        dec         = '0;
        dec.wr_any  = wr;
        dec.wr_mode = wr && (addr == MODE_A);
        dec.wr_prot = wr && (addr == PROT_A);
        dec.rd_mode = rd && (addr == MODE_A);
        dec.rd_prot = rd && (addr == PROT_A);
    end
endmodule

// File: rtl/tmr_mode_guard.sv
module tmr_mode_guard
    import tmr_mode_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  decode_t dec,
    input  logic    unlk_bit,
    input  logic    lock_bit,
    output logic    lock,
    output logic    open
);
    guard_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        // Arming: a read that shows the lock set; any write consumes it
        if (dec.rd_prot && g_q.lock)
            g_d.armed = 1'b1;
        else if (dec.wr_any)
            g_d.armed = 1'b0;
        // Lock transitions: closing has priority over opening
        if (dec.wr_prot && lock_bit)
            g_d.lock = 1'b1;
        else if (dec.wr_mode && unlk_bit && g_q.armed)
            g_d.lock = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q.lock  <= 1'b1;
            g_q.armed <= 1'b0;
        end else begin
            g_q <= g_d;
        end
    end

    assign lock = g_q.lock;
    assign open = ~g_q.lock;
endmodule

// File: rtl/tmr_mode_fields.sv
module tmr_mode_fields
    import tmr_mode_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_mode,
    input  logic open,
    input  logic capt_bit,
    input  logic sync_bit,
    input  logic init_bit,
    input  logic feat_bit,
    output logic cap_test,
    output logic sync_sel,
    output logic feat_en,
    output logic init_pls
);
    fields_t f_d, f_q;

    always_comb begin
        f_d          = f_q;
        f_d.init_pls = wr_mode && init_bit;
        if (wr_mode) begin
            f_d.sync_sel = sync_bit;
            if (open) begin
                f_d.cap_test = capt_bit;
                f_d.feat_en  = feat_bit;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign cap_test = f_q.cap_test;
    assign sync_sel = f_q.sync_sel;
    assign feat_en  = f_q.feat_en;
    assign init_pls = f_q.init_pls;
endmodule

// File: rtl/tmr_mode_reg.sv
module tmr_mode_reg
    import tmr_mode_pkg::*;
#(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned MODE_OFS = 0,
    parameter int unsigned PROT_OFS = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              cap_test_o,
    output logic              sync_sel_o,
    output logic              feat_en_o,
    output logic              lock_o,
    output logic              guard_open_o,
    output logic              init_pulse_o
);
    decode_t           dec;
    logic              lock, open;
    logic              cap_test, sync_sel, feat_en, init_pls;
    logic [DATA_W-1:0] rdata_d, rdata_q;

    tmr_mode_decode #(
        .ADDR_W  (ADDR_W),
        .MODE_OFS(MODE_OFS),
        .PROT_OFS(PROT_OFS)
    ) u_dec (
        .addr(bus_addr),
        .wr  (bus_wr),
        .rd  (bus_rd),
        .dec (dec)
    );

    tmr_mode_guard u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .dec     (dec),
        .unlk_bit(bus_wdata[UNLK_BIT]),
        .lock_bit(bus_wdata[LOCK_BIT]),
        .lock    (lock),
        .open    (open)
    );

    tmr_mode_fields u_fields (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_mode (dec.wr_mode),
        .open    (open),
        .capt_bit(bus_wdata[CAPT_BIT]),
        .sync_bit(bus_wdata[SYNC_BIT]),
        .init_bit(bus_wdata[INIT_BIT]),
        .feat_bit(bus_wdata[FEAT_BIT]),
        .cap_test(cap_test),
        .sync_sel(sync_sel),
        .feat_en (feat_en),
        .init_pls(init_pls)
    );

    // Read path: registered, the initialise bit always returns 0
    always_comb begin
        rdata_d = '0;
        if (dec.rd_mode) begin
            rdata_d[CAPT_BIT] = cap_test;
            rdata_d[SYNC_BIT] = sync_sel;
            rdata_d[UNLK_BIT] = open;
            rdata_d[FEAT_BIT] = feat_en;
        end
        if (dec.rd_prot)
            rdata_d[LOCK_BIT] = lock;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign bus_rdata    = rdata_q;
    assign cap_test_o   = cap_test;
    assign sync_sel_o   = sync_sel;
    assign feat_en_o    = feat_en;
    assign lock_o       = lock;
    assign guard_open_o = open;
    assign init_pulse_o = init_pls;
endmodule

// File: rtl/tmr_mode_reg_chk.sv
module tmr_mode_reg_chk
    import tmr_mode_pkg::*;
#(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned MODE_OFS = 0,
    parameter int unsigned PROT_OFS = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              cap_test_o,
    input logic              feat_en_o,
    input logic              lock_o,
    input logic              guard_open_o,
    input logic              init_pulse_o
);
    logic mode_wr, prot_wr;
    assign mode_wr = bus_wr && (bus_addr == ADDR_W'(MODE_OFS));
    assign prot_wr = bus_wr && (bus_addr == ADDR_W'(PROT_OFS));

    p_guarded_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && lock_o) |=> ($stable(cap_test_o) && $stable(feat_en_o)));

    p_open_inverse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        guard_open_o == !lock_o);

    p_relock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_wr && bus_wdata[LOCK_BIT]) |=> lock_o);

    p_unlock_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_o) |-> $past(mode_wr && bus_wdata[UNLK_BIT]));

    p_init_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && bus_wdata[INIT_BIT]) |=> init_pulse_o);

    p_init_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        init_pulse_o |-> $past(mode_wr && bus_wdata[INIT_BIT]));

    p_init_reads_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rdata[INIT_BIT]);
endmodule

bind tmr_mode_reg tmr_mode_reg_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .MODE_OFS(MODE_OFS),
    .PROT_OFS(PROT_OFS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .cap_test_o  (cap_test_o),
    .feat_en_o   (feat_en_o),
    .lock_o      (lock_o),
    .guard_open_o(guard_open_o),
    .init_pulse_o(init_pulse_o)
);

// File: tb/tmr_mode_reg_bench.sv
module tmr_mode_reg_bench;
    localparam int unsigned ADDR_W = 4;
    localparam int unsigned DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic              bus_rd = 1'b0;
    logic [DATA_W-1:0] bus_rdata;
    logic cap_test_o, sync_sel_o, feat_en_o, lock_o, guard_open_o, init_pulse_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    tmr_mode_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tmr_mode_reg (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .cap_test_o(cap_test_o), .sync_sel_o(sync_sel_o), .feat_en_o(feat_en_o),
        .lock_o(lock_o), .guard_open_o(guard_open_o), .init_pulse_o(init_pulse_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = ADDR_W'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = ADDR_W'(a); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] r;
        check("R1 lock", 32'(lock_o), 1);
        check("R1 open", 32'(guard_open_o), 0);
        check("R1 fields", {29'b0, cap_test_o, sync_sel_o, feat_en_o}, 0);
        check("R1 pulse", 32'(init_pulse_o), 0);
        check("R1 rdata", bus_rdata, 0);
        bus_read(1, r);
        check("R2 guard word reads lock", r, 32'h1);
    endtask

    task automatic t_locked_drop();
        logic [31:0] r;
        bus_write(0, 32'h13);
        check("R3 cap dropped", 32'(cap_test_o), 0);
        check("R3 feat dropped", 32'(feat_en_o), 0);
        check("R4 sync locked", 32'(sync_sel_o), 1);
        bus_read(0, r);
        check("R2 mode word", r, 32'h02);
        bus_write(0, 32'h04);
        check("R8 no arm read", 32'(lock_o), 1);
    endtask

    task automatic t_unlock_and_open();
        logic [31:0] r;
        bus_read(1, r);
        check("R7 arming read", r, 32'h1);
        bus_write(0, 32'h17);
        check("R7 unlocked", 32'(lock_o), 0);
        check("R5 open flag", 32'(guard_open_o), 1);
        check("R3 same-write cap", 32'(cap_test_o), 0);
        check("R3 same-write feat", 32'(feat_en_o), 0);
        bus_write(0, 32'h11);
        check("R9 zero keeps open", 32'(lock_o), 0);
        check("R3 open cap", 32'(cap_test_o), 1);
        check("R3 open feat", 32'(feat_en_o), 1);
        check("R4 sync open", 32'(sync_sel_o), 0);
        bus_read(0, r);
        check("R5 mode reads open", r, 32'h15);
        bus_read(1, r);
        check("R5 guard word", r, 32'h0);
        bus_read(5, r);
        check("R2 unmapped", r, 32'h0);
    endtask

    task automatic t_relock();
        bus_write(1, 32'h0);
        check("R6 zero no effect", 32'(lock_o), 0);
        bus_write(1, 32'h1);
        check("R6 relock", 32'(lock_o), 1);
        check("R5 closed", 32'(guard_open_o), 0);
        bus_write(0, 32'h00);
        check("R3 hold cap", 32'(cap_test_o), 1);
        check("R3 hold feat", 32'(feat_en_o), 1);
    endtask

    task automatic t_disarm();
        logic [31:0] r;
        bus_read(1, r);
        bus_write(1, 32'h0);
        bus_write(0, 32'h04);
        check("R8 intervening write", 32'(lock_o), 1);
    endtask

    task automatic t_init();
        logic [31:0] r;
        bus_write(0, 32'h08);
        check("R10 pulse locked", 32'(init_pulse_o), 1);
        @(negedge clk);
        check("R10 pulse one cycle", 32'(init_pulse_o), 0);
        bus_write(0, 32'h02);
        check("R10 no pulse on 0", 32'(init_pulse_o), 0);
        bus_read(1, r);
        bus_write(0, 32'h0C);
        check("R10 pulse during unlock", 32'(init_pulse_o), 1);
        check("R7 second unlock", 32'(lock_o), 0);
        bus_write(0, 32'h08);
        check("R10 pulse unlocked", 32'(init_pulse_o), 1);
        bus_read(0, r);
        check("R11 init reads 0", r & 32'h08, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_locked_drop();
        t_unlock_and_open();
        t_relock();
        t_disarm();
        t_init();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end
endmodule